// File: doc/BRIEF.md
# Integer Outer-Product Dot Accumulator

This block applies one update to a square tile of 64-bit accumulators. The update is a widening integer outer product. Each accumulator cell (i, j) takes a four-way multiply-sum of narrow elements. Those elements are packed into row source word i and column source word j. The sum is then added to the cell, or subtracted from it. In byte form, each 64-bit cell is two independent 32-bit lanes. Each lane collects four 8x8 products. In halfword form, the cell is one 64-bit lane that collects four 16x16 products.

Each operand has its own signedness control. The two controls give four product variants: signed x signed, unsigned x unsigned, signed x unsigned and unsigned x signed. A row predicate byte and a column predicate byte are ANDed per cell. The resulting bits switch off individual row-source elements. A pulse on `start` captures all operands. The tile is then updated one row per cycle, with all columns computed in parallel. `done` pulses once the last row has been written. The accumulators can be inspected at any time through a combinational read port. They start from zero at reset and carry their values across operations, so successive operations accumulate.

Top module: `ompa_accum`

## Requirements
- R1: After reset, `busy` and `done` are low and every tile cell reads as zero.
- R2: With `form_half`=0, byte k of a source word is bits [8k+7:8k]. The low 32 bits of cell (i,j) change by the sum over bytes 0..3 of row byte times column byte. The high 32 bits change by the same sum over bytes 4..7.
- R3: With `form_half`=1, halfword e is bits [16e+15:16e]. All four halfword products of the row and column words sum into the full 64-bit cell.
- R4: `n_signed` makes row-source elements two's-complement, and `m_signed` does the same for column-source elements. When a flag is clear, that operand is zero-extended. Each operand is extended by its own flag before the multiply.
- R5: The effective predicate of cell (i,j) is pn byte i AND pm byte j. The bit for a narrow element sits at the position of the element's lowest byte: bit k for byte k, and bit 2e for halfword e. Odd bits have no effect in halfword form. A cleared bit makes that element contribute zero, and a cell with no active element keeps its value.
- R6: With `negate`=1 the product sum is subtracted. Otherwise it is added. In both cases the arithmetic wraps modulo 2^32 per byte-form lane and modulo 2^64 in halfword form.
- R7: In byte form a wrap or borrow in the low 32-bit lane never reaches the high lane.
- R8: A `start` accepted while idle raises `busy`. Rows 0..DIM-1 are then written on the next DIM clock edges. `done` is high for exactly one cycle after the edge that writes the last row, and `busy` is low from that cycle on. A `start` while `busy` is ignored.
- R9: `rd_data` shows cell (`rd_row`,`rd_col`) combinationally, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one tile update (accepted only when idle) |
| form_half | input | 1 | 0: byte form, 1: halfword form |
| n_signed | input | 1 | Row-source elements are signed |
| m_signed | input | 1 | Column-source elements are signed |
| negate | input | 1 | Subtract instead of add |
| zn_vec | input | DIM*64 | Row source words, word i at bits [64i+63:64i] |
| zm_vec | input | DIM*64 | Column source words, word j at bits [64j+63:64j] |
| pn_pred | input | DIM*8 | Row predicate bytes |
| pm_pred | input | DIM*8 | Column predicate bytes |
| rd_row | input | $clog2(DIM) | Read row index |
| rd_col | input | $clog2(DIM) | Read column index |
| busy | output | 1 | Update in progress |
| done | output | 1 | One-cycle pulse after the last row write |
| rd_data | output | 64 | Selected accumulator cell |

## Verification
The checker watches every cycle for three things: the row-by-row sequencing, the single-cycle `done` pulse, and writes that happen only while busy. On every write it also checks that a fully masked cell keeps its value, that odd predicate bits have no effect in halfword form, and that a byte-form write with the upper predicate nibble clear leaves the high lane untouched. Only the bench scenarios can show that the sums are numerically right. These cover all sixteen combinations of form, signedness and negate, the extreme operands, the signed wrap of the accumulators, and the fact that a `start` issued mid-update leaves the tile unchanged.

// File: rtl/ompa_pkg.sv
package ompa_pkg;

  typedef enum logic {
    FORM_BYTE = 1'b0,
    FORM_HALF = 1'b1
  } form_e;

  typedef struct packed {
    form_e form;
    logic  n_sgn;
    logic  m_sgn;
    logic  neg;
  } opcfg_t;

  // 8x8 product, each operand widened by its own sign control, sign-extended to 32
  function automatic logic [31:0] byte_prod(input logic [7:0] a, input logic a_s,
                                            input logic [7:0] b, input logic b_s);
    logic signed [8:0]  ea;
    logic signed [8:0]  eb;
    logic signed [17:0] pr;
    ea = {a_s & a[7], a};
    eb = {b_s & b[7], b};
    pr = ea * eb;
    return {{14{pr[17]}}, pr};
  endfunction

  // 16x16 product, sign-extended to 64
  function automatic logic [63:0] half_prod(input logic [15:0] a, input logic a_s,
                                            input logic [15:0] b, input logic b_s);
    logic signed [16:0] ea;
    logic signed [16:0] eb;
    logic signed [33:0] pr;
    ea = {a_s & a[15], a};
    eb = {b_s & b[15], b};
    pr = ea * eb;
    return {{30{pr[33]}}, pr};
  endfunction

  // four-byte dot product for one 32-bit lane, masked elements contribute zero
  function automatic logic [31:0] quad_byte_sum(input logic [31:0] n, input logic [31:0] m,
                                                input logic [3:0] p, input opcfg_t c);
    logic [31:0] s;
    s = '0;
    for (int k = 0; k < 4; k++) begin
      if (p[k]) s = s + byte_prod(n[8*k +: 8], c.n_sgn, m[8*k +: 8], c.m_sgn);
    end
    return s;
  endfunction

  // four-halfword dot product into 64 bits; predicate bit 2e governs halfword e
  function automatic logic [63:0] quad_half_sum(input logic [63:0] n, input logic [63:0] m,
                                                input logic [7:0] p, input opcfg_t c);
    logic [63:0] s;
    s = '0;
    for (int e = 0; e < 4; e++) begin
      if (p[2*e]) s = s + half_prod(n[16*e +: 16], c.n_sgn, m[16*e +: 16], c.m_sgn);
    end
    return s;
  endfunction

  function automatic logic [31:0] lane32_apply(input logic [31:0] a, input logic [31:0] s,
                                               input logic neg);
    return neg ? (a - s) : (a + s);
  endfunction

  // full cell update
  function automatic logic [63:0] cell_update(input logic [63:0] a, input logic [63:0] n,
                                              input logic [63:0] m, input logic [7:0] p,
                                              input opcfg_t c);
    logic [63:0] r;
    if (c.form == FORM_HALF) begin
      r = c.neg ? (a - quad_half_sum(n, m, p, c)) : (a + quad_half_sum(n, m, p, c));
    end else begin
      r[31:0]  = lane32_apply(a[31:0],  quad_byte_sum(n[31:0],  m[31:0],  p[3:0], c), c.neg);
      r[63:32] = lane32_apply(a[63:32], quad_byte_sum(n[63:32], m[63:32], p[7:4], c), c.neg);
    end
    return r;
  endfunction

endpackage

// File: rtl/ompa_ctrl.sv
module ompa_ctrl #(
  parameter int DIM = 4,
  localparam int RW = (DIM > 1) ? $clog2(DIM) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          accept,
  output logic          busy,
  output logic          done,
  output logic          wr_en,
  output logic [RW-1:0] row_idx
);
  localparam logic [RW-1:0] LAST_ROW = RW'(DIM - 1);

  logic row_last;

  assign accept   = start & ~busy;
  assign wr_en    = busy;
  assign row_last = busy & (row_idx == LAST_ROW);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      row_idx <= '0;
    end else begin
      done <= row_last;
      if (accept) begin
        busy    <= 1'b1;
        row_idx <= '0;
      end else if (row_last) begin
        busy    <= 1'b0;
        row_idx <= '0;
      end else if (busy) begin
        row_idx <= row_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ompa_opreg.sv
module ompa_opreg
  import ompa_pkg::*;
#(
  parameter int DIM = 4,
  localparam int RW = (DIM > 1) ? $clog2(DIM) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  opcfg_t            cfg_in,
  input  logic [DIM*64-1:0] zn_in,
  input  logic [DIM*64-1:0] zm_in,
  input  logic [DIM*8-1:0]  pn_in,
  input  logic [DIM*8-1:0]  pm_in,
  input  logic [RW-1:0]     row_idx,
  output opcfg_t            cfg_q,
  output logic [63:0]       zn_row,
  output logic [7:0]        pn_row,
  output logic [DIM*64-1:0] zm_q,
  output logic [DIM*8-1:0]  pm_q
);
  logic [DIM*64-1:0] zn_q;
  logic [DIM*8-1:0]  pn_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      zn_q  <= '0;
      zm_q  <= '0;
      pn_q  <= '0;
      pm_q  <= '0;
    end else if (accept) begin
      cfg_q <= cfg_in;
      zn_q  <= zn_in;
      zm_q  <= zm_in;
      pn_q  <= pn_in;
      pm_q  <= pm_in;
    end
  end

  assign zn_row = zn_q[64*row_idx +: 64];
  assign pn_row = pn_q[8*row_idx +: 8];
endmodule

// File: rtl/ompa_lane.sv
module ompa_lane
  import ompa_pkg::*;
(
  input  logic [63:0] acc_old,
  input  logic [63:0] n_word,
  input  logic [63:0] m_word,
  input  logic [7:0]  pn_byte,
  input  logic [7:0]  pm_byte,
  input  opcfg_t      cfg,
  output logic [7:0]  pred_eff,
  output logic [63:0] acc_new
);
  assign pred_eff = pn_byte & pm_byte;
  assign acc_new  = cell_update(acc_old, n_word, m_word, pred_eff, cfg);
endmodule

// File: rtl/ompa_tile.sv
module ompa_tile #(
  parameter int DIM = 4,
  localparam int RW = (DIM > 1) ? $clog2(DIM) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [RW-1:0]     row_idx,
  input  logic [DIM*64-1:0] row_new,
  output logic [DIM*64-1:0] row_old,
  input  logic [RW-1:0]     rd_row,
  input  logic [RW-1:0]     rd_col,
  output logic [63:0]       rd_data
);
  logic [63:0] cells [DIM][DIM];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < DIM; r++)
        for (int c = 0; c < DIM; c++)
          cells[r][c] <= '0;
    end else if (wr_en) begin
      for (int c = 0; c < DIM; c++)
        cells[row_idx][c] <= row_new[64*c +: 64];
    end
  end

  for (genvar c = 0; c < DIM; c++) begin : g_old
    assign row_old[64*c +: 64] = cells[row_idx][c];
  end

  assign rd_data = cells[rd_row][rd_col];
endmodule

// File: rtl/ompa_accum.sv
module ompa_accum
  import ompa_pkg::*;
#(
  parameter int DIM = 4,
  localparam int RW = (DIM > 1) ? $clog2(DIM) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              form_half,
  input  logic              n_signed,
  input  logic              m_signed,
  input  logic              negate,
  input  logic [DIM*64-1:0] zn_vec,
  input  logic [DIM*64-1:0] zm_vec,
  input  logic [DIM*8-1:0]  pn_pred,
  input  logic [DIM*8-1:0]  pm_pred,
  input  logic [RW-1:0]     rd_row,
  input  logic [RW-1:0]     rd_col,
  output logic              busy,
  output logic              done,
  output logic [63:0]       rd_data
);
  opcfg_t            cfg_in;
  opcfg_t            cfg_q;
  logic              accept;
  logic              wr_en;
  logic [RW-1:0]     row_idx;
  logic [63:0]       zn_row;
  logic [7:0]        pn_row;
  logic [DIM*64-1:0] zm_q;
  logic [DIM*8-1:0]  pm_q;
  logic [DIM*64-1:0] row_old;
  logic [DIM*64-1:0] row_new;
  logic [DIM*8-1:0]  pred_row;

  assign cfg_in.form  = form_half ? FORM_HALF : FORM_BYTE;
  assign cfg_in.n_sgn = n_signed;
  assign cfg_in.m_sgn = m_signed;
  assign cfg_in.neg   = negate;

  ompa_ctrl #(.DIM(DIM)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .accept(accept),
    .busy(busy), .done(done), .wr_en(wr_en), .row_idx(row_idx)
  );

  ompa_opreg #(.DIM(DIM)) u_opreg (
    .clk(clk), .rst_n(rst_n), .accept(accept), .cfg_in(cfg_in),
    .zn_in(zn_vec), .zm_in(zm_vec), .pn_in(pn_pred), .pm_in(pm_pred),
    .row_idx(row_idx), .cfg_q(cfg_q), .zn_row(zn_row), .pn_row(pn_row),
    .zm_q(zm_q), .pm_q(pm_q)
  );

  for (genvar c = 0; c < DIM; c++) begin : g_col
    ompa_lane u_lane (
      .acc_old (row_old[64*c +: 64]),
      .n_word  (zn_row),
      .m_word  (zm_q[64*c +: 64]),
      .pn_byte (pn_row),
      .pm_byte (pm_q[8*c +: 8]),
      .cfg     (cfg_q),
      .pred_eff(pred_row[8*c +: 8]),
      .acc_new (row_new[64*c +: 64])
    );
  end

  ompa_tile #(.DIM(DIM)) u_tile (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .row_idx(row_idx),
    .row_new(row_new), .row_old(row_old),
    .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data)
  );
endmodule

// File: rtl/ompa_accum_chk.sv
module ompa_accum_chk #(
  parameter int DIM = 4,
  localparam int RW = (DIM > 1) ? $clog2(DIM) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          wr_en,
  input logic [RW-1:0] row_idx,
  input logic          form_q,
  input logic [7:0]    pred_c0,
  input logic [63:0]   old_c0,
  input logic [63:0]   new_c0
);
  localparam logic [RW-1:0] LAST_ROW = RW'(DIM - 1);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));

  p_row_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && row_idx != LAST_ROW) |=> (busy && row_idx == $past(row_idx) + 1'b1));

  p_idle_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_en);

  p_masked_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && pred_c0 == 8'h00) |-> (new_c0 == old_c0));

  p_odd_bits_inert_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && form_q && (pred_c0 & 8'h55) == 8'h00) |-> (new_c0 == old_c0));

  p_no_lane_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !form_q && pred_c0[7:4] == 4'h0) |-> (new_c0[63:32] == old_c0[63:32]));
endmodule

bind ompa_accum ompa_accum_chk #(.DIM(DIM)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .busy   (busy),
  .done   (done),
  .wr_en  (wr_en),
  .row_idx(row_idx),
  .form_q (cfg_q.form),
  .pred_c0(pred_row[7:0]),
  .old_c0 (row_old[63:0]),
  .new_c0 (row_new[63:0])
);

// File: tb/sim_ompa_accum.sv
module sim_ompa_accum;
  localparam int DIM = 4;
  localparam int RW = 2;
  localparam time CLK_PERIOD = 10ns;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic              form_half, n_signed, m_signed, negate;
  logic [DIM*64-1:0] zn_vec, zm_vec;
  logic [DIM*8-1:0]  pn_pred, pm_pred;
  logic [RW-1:0]     rd_row, rd_col;
  logic              busy, done;
  logic [63:0]       rd_data;

  int n_vec = 0;
  int n_bad = 0;
  logic [63:0] model [DIM][DIM];

  always #(CLK_PERIOD/2) clk = ~clk;

  ompa_accum #(.DIM(DIM)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .form_half(form_half),
    .n_signed(n_signed), .m_signed(m_signed), .negate(negate),
    .zn_vec(zn_vec), .zm_vec(zm_vec), .pn_pred(pn_pred), .pm_pred(pm_pred),
    .rd_row(rd_row), .rd_col(rd_col), .busy(busy), .done(done), .rd_data(rd_data)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // bench-side arithmetic, written with wide signed integers
  function automatic longint ext(input logic [15:0] v, input int bits, input logic sg);
    longint x;
    x = longint'(v) & ((longint'(1) << bits) - 1);
    if (sg && v[bits-1]) x = x - (longint'(1) << bits);
    return x;
  endfunction

  function automatic logic [63:0] ref_cell(input logic [63:0] a, input logic [63:0] n,
                                           input logic [63:0] m, input logic [7:0] p,
                                           input logic hf, input logic ns, input logic ms,
                                           input logic ng);
    logic [63:0] r;
    longint s, acc;
    if (hf) begin
      s = 0;
      for (int e = 0; e < 4; e++)
        if (p[2*e]) s += ext(n[16*e +: 16], 16, ns) * ext(m[16*e +: 16], 16, ms);
      acc = longint'(a);
      r = ng ? 64'(acc - s) : 64'(acc + s);
    end else begin
      for (int h = 0; h < 2; h++) begin
        s = 0;
        for (int e = 0; e < 4; e++)
          if (p[4*h+e]) s += ext({8'h0, n[32*h+8*e +: 8]}, 8, ns) * ext({8'h0, m[32*h+8*e +: 8]}, 8, ms);
        acc = longint'(a[32*h +: 32]);
        acc = ng ? acc - s : acc + s;
        r[32*h +: 32] = acc[31:0];
      end
    end
    return r;
  endfunction

  task automatic compare_tile(input string tag);
    for (int r = 0; r < DIM; r++)
      for (int c = 0; c < DIM; c++) begin
        rd_row = RW'(r);
        rd_col = RW'(c);
        #1;
        check(tag, rd_data, model[r][c]);
      end
  endtask

  // one operation; poke=1 issues a spurious start while busy (R8)
  task automatic run_op(input string tag, input logic hf, input logic ns, input logic ms,
                        input logic ng, input logic [DIM*64-1:0] n, input logic [DIM*64-1:0] m,
                        input logic [DIM*8-1:0] pn, input logic [DIM*8-1:0] pm, input logic poke);
    int lat;
    @(negedge clk);
    form_half = hf; n_signed = ns; m_signed = ms; negate = ng;
    zn_vec = n; zm_vec = m; pn_pred = pn; pm_pred = pm;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    zn_vec = ~n; pm_pred = '1; negate = ~ng;
    for (int r = 0; r < DIM; r++)
      for (int c = 0; c < DIM; c++)
        model[r][c] = ref_cell(model[r][c], n[64*r +: 64], m[64*c +: 64],
                               pn[8*r +: 8] & pm[8*c +: 8], hf, ns, ms, ng);
    check("R8 busy after start", {63'b0, busy}, 64'd1);
    lat = 0;
    while (!done && lat < 20) begin
      if (poke && lat == 1) start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    check("R8 done latency", 64'(lat), 64'(DIM));
    check("R8 idle at done", {63'b0, busy}, 64'd0);
    compare_tile(tag);
    @(posedge clk);
    @(negedge clk);
    check("R8 done one cycle", {63'b0, done}, 64'd0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int r = 0; r < DIM; r++)
      for (int c = 0; c < DIM; c++) model[r][c] = '0;
  endtask

  function automatic logic [DIM*64-1:0] rnd_vec();
    logic [DIM*64-1:0] v;
    for (int i = 0; i < DIM*2; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [DIM*8-1:0] rnd_pred(input int dense);
    logic [DIM*8-1:0] v;
    for (int i = 0; i < DIM*8; i++) v[i] = ($urandom % 4) < dense;
    return v;
  endfunction

  initial begin
    start = 0; form_half = 0; n_signed = 0; m_signed = 0; negate = 0;
    zn_vec = '0; zm_vec = '0; pn_pred = '0; pm_pred = '0; rd_row = '0; rd_col = '0;
    void'($urandom(32'h5eed));
    do_reset();
    check("R1 busy low", {63'b0, busy}, 64'd0);
    check("R1 done low", {63'b0, done}, 64'd0);
    compare_tile("R1 tile zero / R9 read");

    // R7 and R6: borrow in low lane from zero, high lane untouched
    run_op("R7 low borrow", 1'b0, 1'b0, 1'b0, 1'b1,
           {DIM{64'h0000_0000_0000_0001}}, {DIM{64'h0000_0000_0000_0001}},
           {DIM{8'h01}}, {DIM{8'h01}}, 1'b0);
    rd_row = 0; rd_col = 0; #1;
    check("R7 explicit value", rd_data, 64'h0000_0000_FFFF_FFFF);

    // R5: halfword form with only odd predicate bits changes nothing
    run_op("R5 odd bits inert", 1'b1, 1'b1, 1'b1, 1'b0, rnd_vec(), rnd_vec(),
           {DIM{8'hAA}}, {DIM{8'hFF}}, 1'b0);

    do_reset();
    // R2/R4 extreme bytes: -128*-128*4 = 65536 per lane
    run_op("R2 R4 signed -128 sq", 1'b0, 1'b1, 1'b1, 1'b0,
           {DIM{64'h8080_8080_8080_8080}}, {DIM{64'h8080_8080_8080_8080}},
           '1, '1, 1'b0);
    rd_row = 1; rd_col = 2; #1;
    check("R2 explicit 65536 lanes", rd_data, 64'h0001_0000_0001_0000);
    // 255*255*4 = 260100 per lane, unsigned
    run_op("R4 unsigned 255 sq", 1'b0, 1'b0, 1'b0, 1'b0,
           {DIM{64'hFFFF_FFFF_FFFF_FFFF}}, {DIM{64'hFFFF_FFFF_FFFF_FFFF}},
           '1, '1, 1'b0);
    // R3 halfword 0x8000 signed squared: 2^30*4 = 2^32
    run_op("R3 half -32768 sq", 1'b1, 1'b1, 1'b1, 1'b0,
           {DIM{64'h8000_8000_8000_8000}}, {DIM{64'h8000_8000_8000_8000}},
           '1, '1, 1'b0);
    // R6 signed wrap: subtract large unsigned halfword products repeatedly
    for (int k = 0; k < 3; k++)
      run_op("R6 half negate wrap", 1'b1, 1'b0, 1'b0, 1'b1,
             {DIM{64'hFFFF_FFFF_FFFF_FFFF}}, {DIM{64'hFFFF_FFFF_FFFF_FFFF}},
             '1, '1, 1'b0);
    run_op("R6 byte negate wrap", 1'b0, 1'b0, 1'b0, 1'b1,
           {DIM{64'hFFFF_FFFF_FFFF_FFFF}}, {DIM{64'hFFFF_FFFF_FFFF_FFFF}},
           '1, '1, 1'b0);

    // R8: a start during busy must not disturb the update
    run_op("R8 start while busy ignored", 1'b0, 1'b1, 1'b0, 1'b0, rnd_vec(), rnd_vec(),
           '1, '1, 1'b1);

    // sweep of all form / signedness / negate combinations (R2 R3 R4 R5 R6)
    for (int pass = 0; pass < 2; pass++)
      for (int mode = 0; mode < 16; mode++)
        run_op("R2 R3 R4 R5 R6 sweep", mode[3], mode[2], mode[1], mode[0],
               rnd_vec(), rnd_vec(), rnd_pred(pass == 0 ? 4 : 2), rnd_pred(3), 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule